// File: doc/BRIEF.md
# Five-State Coherence Line Controller

This block tracks the coherence state of every line in one private, direct-mapped cache that runs a five-state protocol: Invalid, Shared, Exclusive, Forward and Modified. Forward marks the one clean sharer that answers remote reads, so plain sharers never send duplicate data. Each cycle the block accepts at most one request: a local read or local write from the processor, or a snooped remote read or remote write/invalidate. It looks up the addressed line in a small tag and state array, updates that line, and one cycle later reports the line's resulting state. With that state it returns any write-back demand, any snoop data-response enable and any bus transaction the local side must issue.

On a local read miss the fill answer comes in with the request. The `fill_shared` input says whether some other cache still holds the line, and this picks between Exclusive and Forward for the new line. Data storage, the interconnect and memory are outside the block. The neighbouring logic moves data whenever `wb_req` or `snoop_data_en` is raised.

Top module: `coh5_line_ctrl`

## Requirements
- R1: Reset sets every line to Invalid. While reset is held and after it, with no request, `rsp_valid` is 0 and every other output is 0. A snoop to any address right after reset reports a miss with state Invalid.
- R2: A request sampled at a rising edge gives `rsp_valid`=1 and its results right after that edge. An idle cycle gives all outputs 0. Requests may come back to back, and each one sees the state left by the one before. State codes are I=0, S=1, E=2, F=3, M=4. Request codes on `req_kind` are local read=0, local write=1, snoop read=2, snoop invalidate=3. Bus codes on `bus_req` are none=0, read=1, read-for-ownership=2, invalidate=3.
- R3: A local read that misses issues a bus read (1). The line is installed as Exclusive when `fill_shared`=0 and as Forward when `fill_shared`=1. A line whose tag matches but which is Invalid counts as a miss.
- R4: A local read hit leaves the state unchanged, issues no bus request and reports `rsp_hit`=1.
- R5: A snoop read that hits a Forward or Exclusive line raises `snoop_data_en` and moves the line to Shared. A snoop read that hits a Shared line responds with nothing and leaves it Shared.
- R6: A snoop read that hits a Modified line raises both `wb_req` and `snoop_data_en` and moves the line to Shared.
- R7: A local write that hits moves the line to Modified. From Shared or Forward it issues a bus invalidate (3). From Exclusive or Modified it issues no bus request.
- R8: A local write that misses issues a read-for-ownership (2) and installs the line as Modified.
- R9: A snoop invalidate that hits a valid line moves it to Invalid and never raises `snoop_data_en`. It raises `wb_req` only when the line was Modified.
- R10: A snoop to a line that is Invalid, or whose tag differs, reports a miss with state Invalid, raises neither `wb_req` nor `snoop_data_en`, and leaves the resident line unchanged.
- R11: A local miss that replaces a Modified line of a different tag raises `wb_req`. Replacing a clean line does not.
- R12: Snoop requests never issue a bus request. `snoop_data_en` is raised only for a snoop read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Request code: 0 local read, 1 local write, 2 snoop read, 3 snoop invalidate |
| req_addr | input | ADDR_W | Line address: low IDX_W bits index, the rest tag |
| fill_shared | input | 1 | Fill answer for a local read miss: another cache holds the line |
| rsp_valid | output | 1 | Results of the previous cycle's request are present |
| rsp_hit | output | 1 | The addressed line was resident and valid |
| rsp_state | output | 3 | Resulting state of the addressed line (I=0, S=1, E=2, F=3, M=4) |
| wb_req | output | 1 | Write the Modified line (snooped or evicted) back to memory |
| snoop_data_en | output | 1 | Supply line data to the remote requester |
| bus_req | output | 2 | Bus transaction to issue: 0 none, 1 read, 2 read-for-ownership, 3 invalidate |

## Verification
The bench builds the block with ADDR_W=10 and IDX_W=3, so there are eight lines and a 7-bit tag. Addresses 8 apart share an index, which makes tag conflicts and evictions easy to reach: snoops that miss on a tag mismatch, replacement of a Modified victim and replacement of a clean victim. With eight lines, every path through all five states, including repeated fills of the same index, fits in a short directed sequence.

// File: rtl/coh5_pkg.sv
package coh5_pkg;

   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_F = 3'd3,
      ST_M = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      RQ_LRD  = 2'd0,
      RQ_LWR  = 2'd1,
      RQ_SRD  = 2'd2,
      RQ_SINV = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      BUS_NONE = 2'd0,
      BUS_RD   = 2'd1,
      BUS_RFO  = 2'd2,
      BUS_INV  = 2'd3
   } bus_op_e;

endpackage

// File: rtl/coh5_line_store.sv
module coh5_line_store
   import coh5_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int TAG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] line_idx,
   output line_st_e         rd_state,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  line_st_e         wr_state,
   input  logic [TAG_W-1:0] wr_tag
);

   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0][2:0]       st_all;
   logic [LINES-1:0][TAG_W-1:0] tag_all;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e         st_r;
      logic [TAG_W-1:0] tag_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= ST_I;
            tag_r <= '0;
         end else if (wr_en && (line_idx == IDX_W'(g))) begin
            st_r  <= wr_state;
            tag_r <= wr_tag;
         end
      end

      assign st_all[g]  = st_r;
      assign tag_all[g] = tag_r;
   end

   assign rd_state = line_st_e'(st_all[line_idx]);
   assign rd_tag   = tag_all[line_idx];

endmodule

// File: rtl/coh5_next_state.sv
module coh5_next_state
   import coh5_pkg::*;
(
   input  req_kind_e kind,
   input  logic      tag_match,
   input  line_st_e  cur_state,
   input  logic      fill_shared,
   output logic      upd,
   output line_st_e  nxt_state,
   output line_st_e  rsp_state,
   output logic      hit,
   output logic      wb,
   output logic      data_en,
   output bus_op_e   bus
);

   logic victim_dirty;

   assign hit          = tag_match && (cur_state != ST_I);
   assign victim_dirty = !tag_match && (cur_state == ST_M);

   always_comb begin
      upd       = 1'b0;
      nxt_state = cur_state;
      wb        = 1'b0;
      data_en   = 1'b0;
      bus       = BUS_NONE;
      unique case (kind)
         RQ_LRD: begin
            if (!hit) begin
               upd       = 1'b1;
               nxt_state = fill_shared ? ST_F : ST_E;
               bus       = BUS_RD;
               wb        = victim_dirty;
            end
         end
         RQ_LWR: begin
            upd       = 1'b1;
            nxt_state = ST_M;
            if (!hit) begin
               bus = BUS_RFO;
               wb  = victim_dirty;
            end else if (cur_state == ST_S || cur_state == ST_F) begin
               bus = BUS_INV;
            end
         end
         RQ_SRD: begin
            if (hit) begin
               upd       = 1'b1;
               nxt_state = ST_S;
               data_en   = (cur_state != ST_S);
               wb        = (cur_state == ST_M);
            end
         end
         RQ_SINV: begin
            if (hit) begin
               upd       = 1'b1;
               nxt_state = ST_I;
               wb        = (cur_state == ST_M);
            end
         end
         default: ;
      endcase
      if (upd)      rsp_state = nxt_state;
      else if (hit) rsp_state = cur_state;
      else          rsp_state = ST_I;
   end

endmodule

// File: rtl/coh5_line_ctrl.sv
module coh5_line_ctrl
   import coh5_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              fill_shared,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [2:0]        rsp_state,
   output logic              wb_req,
   output logic              snoop_data_en,
   output logic [1:0]        bus_req
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10 || TAG_W < 1) begin : g_param_bad
      $error("coh5_line_ctrl: IDX_W must be 1..10 and smaller than ADDR_W");
   end

   logic [IDX_W-1:0] line_idx;
   logic [TAG_W-1:0] req_tag;
   line_st_e         cur_state;
   logic [TAG_W-1:0] cur_tag;
   logic             upd;
   line_st_e         nxt_state;
   line_st_e         res_state;
   logic             hit;
   logic             wb;
   logic             data_en;
   bus_op_e          bus;

   assign line_idx = req_addr[IDX_W-1:0];
   assign req_tag  = req_addr[ADDR_W-1:IDX_W];

   coh5_line_store #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_idx (line_idx),
      .rd_state (cur_state),
      .rd_tag   (cur_tag),
      .wr_en    (req_valid && upd),
      .wr_state (nxt_state),
      .wr_tag   (req_tag)
   );

   coh5_next_state u_next (
      .kind        (req_kind_e'(req_kind)),
      .tag_match   (cur_tag == req_tag),
      .cur_state   (cur_state),
      .fill_shared (fill_shared),
      .upd         (upd),
      .nxt_state   (nxt_state),
      .rsp_state   (res_state),
      .hit         (hit),
      .wb          (wb),
      .data_en     (data_en),
      .bus         (bus)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !req_valid) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_state     <= ST_I;
         wb_req        <= 1'b0;
         snoop_data_en <= 1'b0;
         bus_req       <= BUS_NONE;
      end else begin
         rsp_valid     <= 1'b1;
         rsp_hit       <= hit;
         rsp_state     <= res_state;
         wb_req        <= wb;
         snoop_data_en <= data_en;
         bus_req       <= bus;
      end
   end

endmodule

// File: rtl/coh5_line_chk.sv
module coh5_line_chk
   import coh5_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_kind,
   input logic       rsp_valid,
   input logic       rsp_hit,
   input logic [2:0] rsp_state,
   input logic       wb_req,
   input logic       snoop_data_en,
   input logic [1:0] bus_req
);

   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !wb_req && !snoop_data_en && bus_req == BUS_NONE));

   a_r2_state_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_state <= 3'd4));

   a_r3_read_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == RQ_LRD) |=>
         (rsp_state != ST_I && (bus_req == BUS_NONE || bus_req == BUS_RD)));

   a_r7_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == RQ_LWR) |=> (rsp_state == ST_M));

   a_r8_write_miss_rfo: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == RQ_LWR) |=> (rsp_hit != (bus_req == BUS_RFO)));

   a_r5_snoop_read_result: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == RQ_SRD) |=> (rsp_state == ST_S || rsp_state == ST_I));

   a_r9_inval_ends_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == RQ_SINV) |=> (rsp_state == ST_I && !snoop_data_en));

   a_r10_snoop_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind[1]) |=> (rsp_hit || (!wb_req && !snoop_data_en)));

   a_r12_snoop_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind[1]) |=> (bus_req == BUS_NONE));

   a_r12_data_only_snoop_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != RQ_SRD) |=> !snoop_data_en);

endmodule

bind coh5_line_ctrl coh5_line_chk u_chk (.*);

// File: tb/test_coh5_line_ctrl.sv
module test_coh5_line_ctrl;

   localparam int AW = 10;
   localparam int IW = 3;

   localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_F = 3'd3, S_M = 3'd4;
   localparam logic [1:0] K_LRD = 2'd0, K_LWR = 2'd1, K_SRD = 2'd2, K_SINV = 2'd3;
   localparam logic [1:0] B_NO = 2'd0, B_RD = 2'd1, B_RFO = 2'd2, B_INV = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic          fill_shared = 1'b0;
   logic          rsp_valid, rsp_hit, wb_req, snoop_data_en;
   logic [2:0]    rsp_state;
   logic [1:0]    bus_req;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      string      rq;
      logic [7:0] vec;
   } exp_t;

   exp_t exp_q[$];

   always #2 clk = ~clk;

   coh5_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) i_coh5_line_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_kind      (req_kind),
      .req_addr      (req_addr),
      .fill_shared   (fill_shared),
      .rsp_valid     (rsp_valid),
      .rsp_hit       (rsp_hit),
      .rsp_state     (rsp_state),
      .wb_req        (wb_req),
      .snoop_data_en (snoop_data_en),
      .bus_req       (bus_req)
   );

   // packed view: {hit, state[2:0], wb, data, bus[1:0]}
   function automatic logic [7:0] pack(input logic h, input logic [2:0] s,
                                       input logic w, input logic d, input logic [1:0] b);
      return {h, s, w, d, b};
   endfunction

   task automatic issue(input string rq, input logic [1:0] k, input logic [AW-1:0] a,
                        input logic fs, input logic eh, input logic [2:0] es,
                        input logic ew, input logic ed, input logic [1:0] eb);
      exp_t e;
      @(negedge clk);
      req_valid   = 1'b1;
      req_kind    = k;
      req_addr    = a;
      fill_shared = fs;
      e.rq  = rq;
      e.vec = pack(eh, es, ew, ed, eb);
      exp_q.push_back(e);
   endtask

   // monitor: compare each response against the oldest expected item (R2 timing)
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R2 unexpected response: actual %h expected none",
                     pack(rsp_hit, rsp_state, wb_req, snoop_data_en, bus_req));
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (pack(rsp_hit, rsp_state, wb_req, snoop_data_en, bus_req) !== e.vec) begin
               n_bad++;
               $display("FAIL %s {hit,st,wb,data,bus}: actual %h expected %h", e.rq,
                        pack(rsp_hit, rsp_state, wb_req, snoop_data_en, bus_req), e.vec);
            end
         end
      end
   end

   task automatic check_idle(input string rq);
      logic [8:0] act;
      act = {rsp_valid, pack(rsp_hit, rsp_state, wb_req, snoop_data_en, bus_req)};
      n_cmp++;
      if (act !== 9'd0) begin
         n_bad++;
         $display("FAIL %s idle outputs: actual %h expected 000", rq, act);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // R1: everything Invalid after reset
      issue("R1", K_SRD,  10'h010, 0, 0, S_I, 0, 0, B_NO);
      issue("R1", K_SINV, 10'h3FF, 0, 0, S_I, 0, 0, B_NO);
      // R3 / R4 / R5 / R7 / R6 / R9 chain on line 1
      issue("R3", K_LRD,  10'h001, 0, 0, S_E, 0, 0, B_RD);
      issue("R4", K_LRD,  10'h001, 1, 1, S_E, 0, 0, B_NO);
      issue("R5 E", K_SRD, 10'h001, 0, 1, S_S, 0, 1, B_NO);
      issue("R5 S", K_SRD, 10'h001, 0, 1, S_S, 0, 0, B_NO);
      issue("R7 S", K_LWR, 10'h001, 0, 1, S_M, 0, 0, B_INV);
      issue("R4 M", K_LRD, 10'h001, 0, 1, S_M, 0, 0, B_NO);
      issue("R6", K_SRD,  10'h001, 0, 1, S_S, 1, 1, B_NO);
      issue("R9", K_SINV, 10'h001, 0, 1, S_I, 0, 0, B_NO);
      issue("R3 inv-tag", K_LRD, 10'h001, 0, 0, S_E, 0, 0, B_RD);
      // R3 shared fill and R5 Forward handoff
      issue("R3 F", K_LRD, 10'h002, 1, 0, S_F, 0, 0, B_RD);
      issue("R5 F", K_SRD, 10'h002, 0, 1, S_S, 0, 1, B_NO);
      issue("R3 F2", K_LRD, 10'h003, 1, 0, S_F, 0, 0, B_RD);
      issue("R7 F", K_LWR, 10'h003, 0, 1, S_M, 0, 0, B_INV);
      issue("R7 E", K_LWR, 10'h001, 0, 1, S_M, 0, 0, B_NO);
      issue("R7 M", K_LWR, 10'h001, 0, 1, S_M, 0, 0, B_NO);
      issue("R9 M", K_SINV, 10'h001, 0, 1, S_I, 1, 0, B_NO);
      // R8 write miss; R10 mismatched-tag snoops leave line 4 alone
      issue("R8", K_LWR,  10'h004, 0, 0, S_M, 0, 0, B_RFO);
      issue("R10 rd", K_SRD,  10'h00C, 0, 0, S_I, 0, 0, B_NO);
      issue("R10 inv", K_SINV, 10'h00C, 0, 0, S_I, 0, 0, B_NO);
      issue("R10 kept", K_LRD, 10'h004, 0, 1, S_M, 0, 0, B_NO);
      // R11 evictions on index 4
      issue("R11 dirty", K_LRD, 10'h00C, 0, 0, S_E, 1, 0, B_RD);
      issue("R11 clean", K_LWR, 10'h014, 0, 0, S_M, 0, 0, B_RFO);
      issue("R11 dirty2", K_LRD, 10'h004, 1, 0, S_F, 1, 0, B_RD);
      // R9 on Shared, then R10 snoop to an Invalid line
      issue("R9 S", K_SINV, 10'h002, 0, 1, S_I, 0, 0, B_NO);
      issue("R10 invalid", K_SRD, 10'h002, 0, 0, S_I, 0, 0, B_NO);
      // R8 then R6 with R12 (no bus on snoop)
      issue("R8 b", K_LWR, 10'h005, 0, 0, S_M, 0, 0, B_RFO);
      issue("R6 R12", K_SRD, 10'h005, 0, 1, S_S, 1, 1, B_NO);

      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_idle("R2 idle");
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 responses missing: actual %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog: actual still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule